// File: doc/BRIEF.md
# Wide-Fetch Instruction Splitter

This block is the front end of an in-order core. A fetch stage reads the instruction memory one aligned 64-bit word at a time, advances its own PC by 8 after each request, and keeps going until it is stalled or redirected. A deliver stage then turns every fetched word into two 32-bit instruction packets on a ready/valid output. Both halves of a word are used, so the same word is never read twice.

Each packet carries the raw instruction and a core-state record: the packet's PC, a machine-state (MSR) value and a vector-state word. The MSR read is started together with the memory request, and its value arrives one clock later. That single sample is copied into both packets of the word. This is safe because the issue logic raises the stall input whenever an instruction, a trap included, might change the MSR. A small FIFO sits between the two stages. A redirect input flushes every pending word and restarts fetch at a new PC.

Top module: `ifetch_split`

## Requirements
- R1: After reset, `mem_req_o`, `msr_rd_o` and `out_valid_o` are low, and they stay low until the first redirect.
- R2: When a redirect is taken with no request in flight, a one-cycle `mem_req_o` pulse is issued in the next cycle, with `msr_rd_o` high in that same cycle. `mem_addr_o` is the redirect PC with bits [2:0] cleared.
- R3: After a request, the next one is made only after the previous response has arrived. Its address is the previous address plus 8, unless a redirect was taken in between.
- R4: Each word yields a low packet first and then a high packet. The low packet has `out_insn_o` = data[31:0] and `out_pc_o` = the word address. The high packet has data[63:32] and the word address plus 4. The first packet becomes valid in the cycle after the response edge.
- R5: Both packets of a word carry the same `out_msr_o`, which is the value of `msr_i` sampled at the clock edge that ends the cycle after the request. They also carry the same `out_sv_o`, which is `sv_i` sampled at the edge that ends the request cycle.
- R6: When the redirect PC has bit 2 set, the low half of the first word is dropped. The first packet is the high half, with `out_pc_o` equal to the redirect PC.
- R7: While `stall_i` is high, no new request is issued. A request already in flight still completes. Fetch resumes when `stall_i` falls.
- R8: While `mem_busy_i` is high, no request is issued.
- R9: While `out_valid_o` is high and `out_ready_i` is low, the packet holds steady. With the output blocked, fetch stops after DEPTH words (default 4) are held, and all packets come out later in order.
- R10: A redirect flushes all held words, so `out_valid_o` is low in the next cycle. A response still in flight is discarded, and a new request waits until that response has returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| redirect_i | input | 1 | Flush and restart fetch at `redirect_pc_i` |
| redirect_pc_i | input | 64 | New fetch PC |
| stall_i | input | 1 | Hold fetch (an MSR-changing instruction is pending) |
| mem_req_o | output | 1 | One-cycle read request |
| mem_addr_o | output | 64 | 8-byte-aligned word address |
| mem_busy_i | input | 1 | Memory cannot accept a request this cycle |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Read data |
| msr_rd_o | output | 1 | MSR read strobe, high in the request cycle |
| msr_i | input | 64 | MSR value, valid the cycle after `msr_rd_o` |
| sv_i | input | 32 | Vector-state word, sampled with the request |
| out_valid_o | output | 1 | Packet valid |
| out_ready_i | input | 1 | Consumer accepts the packet |
| out_insn_o | output | 32 | Raw instruction |
| out_pc_o | output | 64 | PC of this instruction |
| out_msr_o | output | 64 | MSR copy for this word |
| out_sv_o | output | 32 | Vector-state copy for this word |

## Verification
Each result has a fixed timing:
- The request pulse is due in the cycle after the redirect edge.
- The MSR value is taken at the edge that ends the cycle after the request.
- The first packet of a word shows in the cycle after the response edge.
- The flush empties the output in the cycle after the redirect.

The bench drives every input at the falling edge and samples one nanosecond later. Its memory model records `sv_i` in the request cycle and `msr_i` one cycle later, keyed by word address, and every packet is compared against those records. The model answers after a latency that each test sets. Request-gap and address-step checks are made on every request, and the stall and busy tests count requests over fixed windows that start after the in-flight response has landed.

// File: rtl/ifs_pkg.sv
// Shared widths and the word record passed from fetch to deliver.
package ifs_pkg;
    localparam int PC_W   = 64;
    localparam int MSR_W  = 64;
    localparam int SV_W   = 32;
    localparam int WORD_W = 64;
    localparam int INSN_W = WORD_W / 2;

    // One fetched word together with the core state captured for it.
    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [PC_W-1:0]   wpc;     // aligned word address
        logic [MSR_W-1:0]  msr;
        logic [SV_W-1:0]   sv;
        logic              skip_lo; // first word after an unaligned redirect
    } word_rec_t;
endpackage

// File: rtl/ifs_fetch.sv
// Fetch stage: issues one aligned 64-bit read at a time, advances the PC
// by 8, and captures sv at issue and the MSR one cycle later.
// Assumes the memory answers in order, at least one cycle after the request,
// and only for requests actually made.
module ifs_fetch
    import ifs_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             redirect_i,
    input  logic [PC_W-1:0]  redirect_pc_i,
    input  logic             stall_i,
    output logic             mem_req_o,
    output logic [PC_W-1:0]  mem_addr_o,
    input  logic             mem_busy_i,
    input  logic             mem_rvalid_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic             msr_rd_o,
    input  logic [MSR_W-1:0] msr_i,
    input  logic [SV_W-1:0]  sv_i,
    input  logic [CW-1:0]    fifo_count_i,
    output logic             push_o,
    output word_rec_t        push_rec_o
);
    logic             run_q, busy_q, drop_q, msr_pend_q, skip_q;
    logic [PC_W-1:0]  pc_q, wpc_q, pc_al;
    logic [MSR_W-1:0] msr_hold_q;
    logic [SV_W-1:0]  sv_hold_q;
    logic             issue;

    // Decide whether a request goes out this cycle.
    always_comb begin
        pc_al = {pc_q[PC_W-1:3], 3'b000};
        issue = run_q && !busy_q && !stall_i && !mem_busy_i && !redirect_i
                && (fifo_count_i < CW'(DEPTH));
    end

    assign mem_req_o  = issue;
    assign msr_rd_o   = issue;
    assign mem_addr_o = pc_al;

    // Hand a response to the FIFO unless it belongs to a flushed request.
    always_comb begin
        push_o             = mem_rvalid_i && busy_q && !drop_q && !redirect_i;
        push_rec_o.data    = mem_rdata_i;
        push_rec_o.wpc     = wpc_q;
        push_rec_o.msr     = msr_pend_q ? msr_i : msr_hold_q;
        push_rec_o.sv      = sv_hold_q;
        push_rec_o.skip_lo = skip_q;
    end

    // Fetch state: PC, outstanding request, discard flag, captured state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q      <= 1'b0;
            busy_q     <= 1'b0;
            drop_q     <= 1'b0;
            msr_pend_q <= 1'b0;
            skip_q     <= 1'b0;
            pc_q       <= '0;
            wpc_q      <= '0;
            msr_hold_q <= '0;
            sv_hold_q  <= '0;
        end else if (redirect_i) begin
            run_q      <= 1'b1;
            pc_q       <= redirect_pc_i;
            msr_pend_q <= 1'b0;
            if (busy_q && !mem_rvalid_i) begin
                drop_q <= 1'b1;
            end else begin
                busy_q <= 1'b0;
                drop_q <= 1'b0;
            end
        end else begin
            if (msr_pend_q) begin
                msr_hold_q <= msr_i;
                msr_pend_q <= 1'b0;
            end
            if (mem_rvalid_i && busy_q) begin
                busy_q <= 1'b0;
                drop_q <= 1'b0;
            end
            if (issue) begin
                busy_q     <= 1'b1;
                msr_pend_q <= 1'b1;
                wpc_q      <= pc_al;
                skip_q     <= pc_q[2];
                sv_hold_q  <= sv_i;
                pc_q       <= pc_al + PC_W'(8);
            end
        end
    end

    // R2
    req_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> !mem_req_o);
    // R7
    stall_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |-> !mem_req_o);
    // R8
    busy_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_busy_i |-> !mem_req_o);
endmodule

// File: rtl/ifs_fifo.sv
// Show-ahead FIFO of fetched word records with a synchronous flush.
// Assumes the writer never pushes while full; pop is ignored when empty.
module ifs_fifo
    import ifs_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic          push_i,
    input  word_rec_t     push_rec_i,
    input  logic          pop_i,
    output logic          empty_o,
    output word_rec_t     head_o,
    output logic [CW-1:0] count_o
);
    word_rec_t     mem_q [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          do_pop;

    assign do_pop  = pop_i && (cnt_q != '0);
    assign empty_o = (cnt_q == '0);
    assign head_o  = mem_q[rd_q];
    assign count_o = cnt_q;

    // Advance a pointer with wrap at DEPTH.
    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    // Storage write.
    always_ff @(posedge clk) begin
        if (push_i) mem_q[wr_q] <= push_rec_i;
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_i) wr_q <= bump(wr_q);
            if (do_pop) rd_q <= bump(rd_q);
            cnt_q <= cnt_q + CW'(push_i) - CW'(do_pop);
        end
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (cnt_q < CW'(DEPTH)));
endmodule

// File: rtl/ifs_deliver.sv
// Deliver stage: presents the FIFO head as a low packet then a high packet,
// or only the high packet when the record is marked skip_lo.
// Assumes the head record is stable until it is popped.
module ifs_deliver
    import ifs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             empty_i,
    input  word_rec_t        head_i,
    output logic             pop_o,
    output logic             out_valid_o,
    input  logic             out_ready_i,
    output logic [INSN_W-1:0] out_insn_o,
    output logic [PC_W-1:0]  out_pc_o,
    output logic [MSR_W-1:0] out_msr_o,
    output logic [SV_W-1:0]  out_sv_o
);
    logic half_q, hi_sel, take;

    // Select the half being presented and build the packet.
    always_comb begin
        hi_sel      = half_q || head_i.skip_lo;
        out_valid_o = !empty_i;
        take        = out_valid_o && out_ready_i;
        pop_o       = take && hi_sel;
        out_insn_o  = hi_sel ? head_i.data[WORD_W-1:INSN_W] : head_i.data[INSN_W-1:0];
        out_pc_o    = head_i.wpc + (hi_sel ? PC_W'(4) : PC_W'(0));
        out_msr_o   = head_i.msr;
        out_sv_o    = head_i.sv;
    end

    // Track which half of the head word is next.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) half_q <= 1'b0;
        else if (take)         half_q <= !hi_sel;
    end

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i && !flush_i) |=>
            ($stable(out_pc_o) && $stable(out_insn_o) && out_valid_o));
    // R10
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !out_valid_o);
endmodule

// File: rtl/ifetch_split.sv
// Top: fetch stage, word FIFO and deliver stage connected in line.
// Assumes the issuer raises stall_i for any MSR-changing instruction, so
// one MSR sample per word is valid for both halves.
module ifetch_split
    import ifs_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              redirect_i,
    input  logic [PC_W-1:0]   redirect_pc_i,
    input  logic              stall_i,
    output logic              mem_req_o,
    output logic [PC_W-1:0]   mem_addr_o,
    input  logic              mem_busy_i,
    input  logic              mem_rvalid_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic              msr_rd_o,
    input  logic [MSR_W-1:0]  msr_i,
    input  logic [SV_W-1:0]   sv_i,
    output logic              out_valid_o,
    input  logic              out_ready_i,
    output logic [INSN_W-1:0] out_insn_o,
    output logic [PC_W-1:0]   out_pc_o,
    output logic [MSR_W-1:0]  out_msr_o,
    output logic [SV_W-1:0]   out_sv_o
);
    logic          push, pop, empty;
    word_rec_t     push_rec, head;
    logic [CW-1:0] count;

    ifs_fetch #(.DEPTH(DEPTH)) u_fetch (
        .clk, .rst_n, .redirect_i, .redirect_pc_i, .stall_i,
        .mem_req_o, .mem_addr_o, .mem_busy_i, .mem_rvalid_i, .mem_rdata_i,
        .msr_rd_o, .msr_i, .sv_i,
        .fifo_count_i(count), .push_o(push), .push_rec_o(push_rec)
    );

    ifs_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk, .rst_n, .flush_i(redirect_i),
        .push_i(push), .push_rec_i(push_rec), .pop_i(pop),
        .empty_o(empty), .head_o(head), .count_o(count)
    );

    ifs_deliver u_deliver (
        .clk, .rst_n, .flush_i(redirect_i),
        .empty_i(empty), .head_i(head), .pop_o(pop),
        .out_valid_o, .out_ready_i, .out_insn_o, .out_pc_o, .out_msr_o, .out_sv_o
    );
endmodule

// File: tb/ifetch_split_tb.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario; a memory model answers requests.
module ifetch_split_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        redirect_i = 1'b0;
    logic [63:0] redirect_pc_i = '0;
    logic        stall_i = 1'b0;
    logic        mem_req_o;
    logic [63:0] mem_addr_o;
    logic        mem_busy_i = 1'b0;
    logic        mem_rvalid_i = 1'b0;
    logic [63:0] mem_rdata_i = '0;
    logic        msr_rd_o;
    logic [63:0] msr_i = '0;
    logic [31:0] sv_i = '0;
    logic        out_valid_o;
    logic        out_ready_i = 1'b0;
    logic [31:0] out_insn_o;
    logic [63:0] out_pc_o;
    logic [63:0] out_msr_o;
    logic [31:0] out_sv_o;

    always #2 clk = ~clk;   // 250 MHz

    ifetch_split dut_i (.*);

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // Memory model state
    int          lat = 1;
    int          cnt = 0;
    bit          mbusy = 0;
    bit          msr_wait = 0;
    logic [63:0] msr_addr, raddr;
    logic [63:0] model_next = '0;
    logic [31:0] vcnt = '0;
    int          n_req = 0;
    logic [63:0] exp_msr [logic [63:0]];
    logic [31:0] exp_sv  [logic [63:0]];

    function automatic logic [31:0] insn_at(input logic [63:0] a);
        return a[31:0] ^ 32'h5A5A_0000;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory model: responds after lat cycles, records sv and MSR per word.
    always @(negedge clk) begin
        #1;
        vcnt++;
        msr_i = {32'hD00D_F00D, vcnt};
        sv_i  = vcnt ^ 32'h0BAD_0000;
        if (msr_wait) begin
            exp_msr[msr_addr] = msr_i;
            msr_wait = 0;
        end
        if (mem_rvalid_i) begin
            mem_rvalid_i = 1'b0;
            mbusy = 0;
        end else if (mbusy) begin
            cnt--;
            if (cnt == 0) begin
                mem_rvalid_i = 1'b1;
                mem_rdata_i  = {insn_at(raddr + 64'd4), insn_at(raddr)};
            end
        end
        if (rst_n && mem_req_o) begin
            n_req++;
            chk(!mbusy, "R3 request while one in flight", 64'(mbusy), 64'd0);
            chk(mem_addr_o == model_next, "R3 request address", mem_addr_o, model_next);
            model_next = mem_addr_o + 64'd8;
            mbusy    = 1;
            cnt      = lat;
            raddr    = mem_addr_o;
            exp_sv[mem_addr_o] = sv_i;
            msr_wait = 1;
            msr_addr = mem_addr_o;
        end
    end

    task automatic redirect(input logic [63:0] pc);
        @(negedge clk);
        redirect_i = 1'b1;
        redirect_pc_i = pc;
        @(posedge clk);
        model_next = pc & ~64'h7;
        @(negedge clk);
        redirect_i = 1'b0;
    endtask

    // Collect n packets from start, checking PC, instruction, MSR and sv.
    task automatic collect(input logic [63:0] start, input int n, input bit toggle,
                           input string tag);
        logic [63:0] p = start;
        int got = 0;
        int t = 0;
        while (got < n && t < 400) begin
            @(negedge clk);
            out_ready_i = toggle ? (t % 3 != 1) : 1'b1;
            #1;
            if (out_valid_o && out_ready_i) begin
                chk(out_pc_o == p, {tag, " packet pc"}, out_pc_o, p);
                chk(out_insn_o == insn_at(p), "R4 packet instruction",
                    64'(out_insn_o), 64'(insn_at(p)));
                chk(exp_msr.exists(p & ~64'h7) && out_msr_o == exp_msr[p & ~64'h7],
                    "R5 packet msr copy", out_msr_o, exp_msr[p & ~64'h7]);
                chk(exp_sv.exists(p & ~64'h7) && out_sv_o == exp_sv[p & ~64'h7],
                    "R5 packet sv copy", 64'(out_sv_o), 64'(exp_sv[p & ~64'h7]));
                p += 64'd4;
                got++;
            end
            t++;
        end
        chk(got == n, {tag, " packet count"}, 64'(got), 64'(n));
    endtask

    task automatic t_reset;   // R1
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); #1;
            chk(!mem_req_o && !msr_rd_o && !out_valid_o, "R1 idle after reset",
                {61'd0, mem_req_o, msr_rd_o, out_valid_o}, 64'd0);
        end
    endtask

    task automatic t_basic;   // R2 R4 R5
        lat = 1;
        out_ready_i = 1'b1;
        redirect(64'h1000);
        #1;
        chk(mem_req_o && msr_rd_o, "R2 request and msr read after redirect",
            {62'd0, mem_req_o, msr_rd_o}, 64'd3);
        chk(mem_addr_o == 64'h1000, "R2 request address", mem_addr_o, 64'h1000);
        @(negedge clk); #1;
        chk(!mem_req_o, "R2 single-cycle pulse", 64'(mem_req_o), 64'd0);
        collect(64'h1000, 8, 1'b0, "R4");
    endtask

    task automatic t_unaligned;   // R6
        lat = 2;
        redirect(64'h2004);
        #1;
        chk(mem_addr_o == 64'h2000, "R6 aligned request address", mem_addr_o, 64'h2000);
        collect(64'h2004, 5, 1'b0, "R6");
    endtask

    task automatic t_stall;   // R7
        int r0;
        lat = 1;
        out_ready_i = 1'b1;
        redirect(64'h6000);
        repeat (4) @(negedge clk);
        stall_i = 1'b1;
        repeat (4) @(negedge clk);
        r0 = n_req;
        repeat (10) @(negedge clk);
        #1;
        chk(n_req == r0, "R7 no request while stalled", 64'(n_req - r0), 64'd0);
        @(negedge clk);
        stall_i = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(n_req > r0, "R7 fetch resumes after stall", 64'(n_req - r0), 64'd1);
    endtask

    task automatic t_busy;   // R8
        int r0;
        lat = 1;
        out_ready_i = 1'b1;
        redirect(64'h7000);
        repeat (4) @(negedge clk);
        mem_busy_i = 1'b1;
        repeat (4) @(negedge clk);
        r0 = n_req;
        repeat (10) @(negedge clk);
        #1;
        chk(n_req == r0, "R8 no request while memory busy", 64'(n_req - r0), 64'd0);
        @(negedge clk);
        mem_busy_i = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(n_req > r0, "R8 request after busy drops", 64'(n_req - r0), 64'd1);
    endtask

    task automatic t_backpressure;   // R9
        int r0;
        lat = 1;
        out_ready_i = 1'b0;
        r0 = n_req;
        redirect(64'h3000);
        repeat (30) @(negedge clk);
        #1;
        chk(n_req - r0 == 4, "R9 fetch stops with FIFO full", 64'(n_req - r0), 64'd4);
        chk(out_valid_o && out_pc_o == 64'h3000, "R9 head packet held",
            out_pc_o, 64'h3000);
        repeat (5) @(negedge clk);
        #1;
        chk(out_valid_o && out_insn_o == insn_at(64'h3000), "R9 held packet stable",
            64'(out_insn_o), 64'(insn_at(64'h3000)));
        collect(64'h3000, 16, 1'b1, "R9");
    endtask

    task automatic t_flush;   // R10
        lat = 3;
        out_ready_i = 1'b0;
        redirect(64'h4000);
        repeat (12) @(negedge clk);
        #1;
        chk(out_valid_o, "R10 words pending before flush", 64'(out_valid_o), 64'd1);
        redirect(64'h5000);
        #1;
        chk(!out_valid_o, "R10 output empty after redirect", 64'(out_valid_o), 64'd0);
        collect(64'h5000, 6, 1'b0, "R10");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_unaligned();
        t_stall();
        t_busy();
        t_backpressure();
        t_flush();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule